// File: doc/BRIEF.md
# UART Register and Interrupt Controller

This block is the register front end of a UART. It is placed between a 32-bit bus and the serial engine. A processor writes characters and configuration through a small set of word registers. It reads back received characters and status, and it changes status flags through a write-only command word. The block contains one receive queue and one transmit queue, each 16 characters deep. It also holds the line configuration and the baud divider, and it keeps six sticky status flags. From the flags it drives one interrupt line.

The block does not shift serial bits and does not time the baud rate. The receiver delivers characters to it together with one-cycle pulses for line break, framing error and parity error. The transmitter pulls characters from the transmit queue one at a time. Neither side needs a handshake.

Reading the data word returns the oldest received character and does not remove it. Software removes that character with a separate command bit. The transmit-ready flag is driven by a programmable occupancy threshold, not by whether the transmit queue has free space.

Top module: `uart_csr_frontend`

## Requirements
- R1: After reset the control and baud registers read 0, both queues are empty, every flag is 0 and the interrupt line is low. The cycle after reset is released, transmit-ready sets because the transmit count of 0 is at or below the threshold of 0.
- R2: The word registers sit at these byte addresses: 0 is data, 4 is control, 8 is baud, 12 is command and 16 is status. Control bits work as follows:
  - Bits 0 to 5 are interrupt enables, in this order: receive-ready, overrun, break, framing, parity, transmit-ready.
  - Bits 8:6 give the word length.
  - Bit 9 enables parity. Bit 10 selects even parity.
  - Bit 11 selects two stop bits.
  - Bit 12 enables flow control.
  - Bit 13 forces the transmit line low.
  - Bits 21:14 give the receive-ready delay.
  - Bits 25:22 give the transmit threshold.
  
  Control reads back its 26 bits. Baud keeps bits 15:0. The command word reads as 0. Each configuration field also appears on its own output.
- R3: A write to address 0 appends bits 7:0 to the transmit queue when the queue holds fewer than 16 characters. When the queue is full, the write is dropped. The transmitter sees the oldest entry on `tx_char` and removes it with `tx_pop`.
- R4: A read of address 0 returns the oldest received character in bits 7:0 and does not remove it. Command bit 10 removes one character.
- R5: Command bit 11 empties the receive queue. Command bit 12 empties the transmit queue.
- R6: The status word holds the flags in bits 5:0, in this order from bit 0: receive-ready, transmit-ready, overrun, break, framing, parity. The receive count is in bits 10:6 and the transmit count is in bits 15:11.
- R7: An accepted received character sets receive-ready. The break, framing and parity pulses set their own flags. A character that arrives while the receive queue is full is dropped and sets overrun.
- R8: Command bits 0 to 4 clear these flags in this order: receive-ready, overrun, break, framing, parity. Command bits 5 to 9 set the same five flags. Flags stay set until they are cleared.
- R9: Transmit-ready sets in every cycle where the transmit count is at or below the threshold. Command bit 13 clears it, but the clear only holds while the count is above the threshold. Command bit 14 sets it.
- R10: When a hardware event and a command clear hit the same flag in the same cycle, the flag ends up set.
- R11: The interrupt line is a register. It holds the OR of every flag ANDed with its enable bit, and it follows the flags one cycle later.
- R12: A remove command on an empty receive queue leaves the queue empty and its count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_break | input | 1 | Line break pulse |
| rx_frame_err | input | 1 | Framing error pulse |
| rx_parity_err | input | 1 | Parity error pulse |
| tx_pop | input | 1 | Transmitter takes the oldest character |
| tx_char | output | 8 | Oldest character in the transmit queue |
| tx_empty | output | 1 | Transmit queue is empty |
| cfg_word_bits | output | 3 | Word length field |
| cfg_parity_en | output | 1 | Parity enable |
| cfg_parity_even | output | 1 | Even parity select |
| cfg_two_stop | output | 1 | Two stop bits |
| cfg_flow_en | output | 1 | Flow control enable |
| cfg_force_low | output | 1 | Hold the transmit line low |
| cfg_rdy_delay | output | 8 | Receive-ready delay |
| baud_cfg | output | 16 | Baud divider word |
| irq | output | 1 | Interrupt request |

## Verification
Two things can act on the same flag in one cycle: a receiver event pulse can arrive in the same cycle as a command write that clears that flag. The bench provokes this by driving the framing-error pulse, and a received character, in the same cycle as a command write that clears framing and receive-ready. It then reads the status word and expects both flags to be set. It also checks that the same clear, issued without a competing event, does take effect. The transmit-ready flag is tested the same way: a clear command competes with the threshold condition. The clear is expected to hold only while the queue occupancy is above the threshold.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
    localparam int NFLAG = 6;
    // flag positions, in status-word order
    localparam int F_RRDY = 0;
    localparam int F_TRDY = 1;
    localparam int F_OE   = 2;
    localparam int F_BRK  = 3;
    localparam int F_FE   = 4;
    localparam int F_PE   = 5;

    localparam logic [4:0] A_DATA = 5'd0;
    localparam logic [4:0] A_CTRL = 5'd4;
    localparam logic [4:0] A_BAUD = 5'd8;
    localparam logic [4:0] A_CMD  = 5'd12;
    localparam logic [4:0] A_STAT = 5'd16;

    localparam int CMD_RX_POP  = 10;
    localparam int CMD_RX_CLR  = 11;
    localparam int CMD_TX_CLR  = 12;
    localparam int CMD_TRDY_LO = 13;
    localparam int CMD_TRDY_HI = 14;

    localparam int STAT_CNT_W = 5;

    typedef struct packed {
        logic [3:0] tx_thresh;
        logic [7:0] rdy_delay;
        logic       force_low;
        logic       flow_en;
        logic       two_stop;
        logic       parity_even;
        logic       parity_en;
        logic [2:0] word_bits;
        logic [5:0] irq_en;
    } ctrl_t;
endpackage

// File: rtl/uart_char_fifo.sv
module uart_char_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= hw_set[i] | sw_set[i] | (flags[i] & ~sw_clr[i]);
        end
    end
endmodule

// File: rtl/uart_csr_frontend.sv
module uart_csr_frontend
    import uart_csr_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CHAR_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_break,
    input  logic              rx_frame_err,
    input  logic              rx_parity_err,
    input  logic              tx_pop,
    output logic [CHAR_W-1:0] tx_char,
    output logic              tx_empty,
    output logic [2:0]        cfg_word_bits,
    output logic              cfg_parity_en,
    output logic              cfg_parity_even,
    output logic              cfg_two_stop,
    output logic              cfg_flow_en,
    output logic              cfg_force_low,
    output logic [7:0]        cfg_rdy_delay,
    output logic [15:0]       baud_cfg,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [15:0]       baud_q;
    logic [NFLAG-1:0]  flag_q, hw_set, sw_set, sw_clr, en_s;
    logic [CNT_W-1:0]  rx_count, tx_count;
    logic              rx_full, rx_empty, tx_full;
    logic [CHAR_W-1:0] rx_head;
    logic              wr_data, wr_ctrl, wr_baud, wr_cmd;
    logic [31:0]       cmd;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_baud = bus_wr && (bus_addr == A_BAUD);
    assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
    assign cmd     = wr_cmd ? bus_wdata : 32'd0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            baud_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[$bits(ctrl_t)-1:0]);
            if (wr_baud) baud_q <= bus_wdata[15:0];
        end
    end

    uart_char_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_rx_fifo (
        .clk, .rst_n,
        .clr   (cmd[CMD_RX_CLR]),
        .push  (rx_push),
        .din   (rx_char),
        .pop   (cmd[CMD_RX_POP]),
        .head  (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    uart_char_fifo #(.DEPTH(DEPTH), .WIDTH(CHAR_W)) u_tx_fifo (
        .clk, .rst_n,
        .clr   (cmd[CMD_TX_CLR]),
        .push  (wr_data),
        .din   (bus_wdata[CHAR_W-1:0]),
        .pop   (tx_pop),
        .head  (tx_char),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    // event sources, command decode and enable remap into status order
    always_comb begin
        hw_set         = '0;
        hw_set[F_RRDY] = rx_push && !rx_full && !cmd[CMD_RX_CLR];
        hw_set[F_TRDY] = 32'(tx_count) <= 32'(ctrl_q.tx_thresh);
        hw_set[F_OE]   = rx_push && rx_full;
        hw_set[F_BRK]  = rx_break;
        hw_set[F_FE]   = rx_frame_err;
        hw_set[F_PE]   = rx_parity_err;

        sw_clr = {cmd[4], cmd[3], cmd[2], cmd[1], cmd[CMD_TRDY_LO], cmd[0]};
        sw_set = {cmd[9], cmd[8], cmd[7], cmd[6], cmd[CMD_TRDY_HI], cmd[5]};

        en_s = {ctrl_q.irq_en[4], ctrl_q.irq_en[3], ctrl_q.irq_en[2],
                ctrl_q.irq_en[1], ctrl_q.irq_en[5], ctrl_q.irq_en[0]};
    end

    uart_flag_bank #(.N(NFLAG)) u_flags (
        .clk, .rst_n,
        .hw_set (hw_set),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .flags  (flag_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flag_q & en_s);
    end

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = 32'(rx_head);
            A_CTRL:  bus_rdata = 32'(ctrl_q);
            A_BAUD:  bus_rdata = 32'(baud_q);
            A_STAT:  bus_rdata = 32'({STAT_CNT_W'(tx_count), STAT_CNT_W'(rx_count), flag_q});
            default: bus_rdata = 32'd0;
        endcase
    end

    assign cfg_word_bits   = ctrl_q.word_bits;
    assign cfg_parity_en   = ctrl_q.parity_en;
    assign cfg_parity_even = ctrl_q.parity_even;
    assign cfg_two_stop    = ctrl_q.two_stop;
    assign cfg_flow_en     = ctrl_q.flow_en;
    assign cfg_force_low   = ctrl_q.force_low;
    assign cfg_rdy_delay   = ctrl_q.rdy_delay;
    assign baud_cfg        = baud_q;
endmodule

// File: rtl/uart_csr_checker.sv
module uart_csr_checker
    import uart_csr_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [4:0]       bus_addr,
    input logic             bus_wr,
    input logic [31:0]      bus_wdata,
    input logic             rx_push,
    input logic             rx_break,
    input logic             rx_frame_err,
    input logic             tx_pop,
    input logic [NFLAG-1:0] flag_q,
    input logic [NFLAG-1:0] en_s,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] tx_count,
    input logic [3:0]       thr,
    input logic             irq
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(rx_count) <= DEPTH) && (32'(tx_count) <= DEPTH)); // R3

    AST_DATA_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DATA && 32'(tx_count) < DEPTH && !tx_pop)
        |=> 32'(tx_count) == 32'($past(tx_count)) + 1); // R3

    AST_BREAK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break |=> flag_q[F_BRK]); // R7

    AST_OVERRUN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && 32'(rx_count) == DEPTH) |=> flag_q[F_OE]); // R7

    AST_TRDY_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_count) <= 32'(thr)) |=> flag_q[F_TRDY]); // R9

    AST_HW_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_err |=> flag_q[F_FE]); // R10

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ($past(flag_q & en_s) != '0))); // R11

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CMD && bus_wdata[CMD_RX_POP] && rx_count == '0 && !rx_push)
        |=> rx_count == '0); // R12
endmodule

bind uart_csr_frontend uart_csr_checker #(.DEPTH(DEPTH)) u_csr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .rx_push      (rx_push),
    .rx_break     (rx_break),
    .rx_frame_err (rx_frame_err),
    .tx_pop       (tx_pop),
    .flag_q       (flag_q),
    .en_s         (en_s),
    .rx_count     (rx_count),
    .tx_count     (tx_count),
    .thr          (ctrl_q.tx_thresh),
    .irq          (irq)
);

// File: tb/test_uart_csr_frontend.sv
module test_uart_csr_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_char = '0;
    logic        rx_break = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_char;
    logic        tx_empty;
    logic [2:0]  cfg_word_bits;
    logic        cfg_parity_en, cfg_parity_even, cfg_two_stop, cfg_flow_en, cfg_force_low;
    logic [7:0]  cfg_rdy_delay;
    logic [15:0] baud_cfg;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_csr_frontend i_uart_csr_frontend (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
        .rx_push, .rx_char, .rx_break, .rx_frame_err, .rx_parity_err,
        .tx_pop, .tx_char, .tx_empty,
        .cfg_word_bits, .cfg_parity_en, .cfg_parity_even, .cfg_two_stop,
        .cfg_flow_en, .cfg_force_low, .cfg_rdy_delay, .baud_cfg, .irq
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rx_in(input logic [7:0] c);
        @(negedge clk);
        rx_push = 1'b1; rx_char = c;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(16, d); chk("R1 status after reset", d, 32'h2);
        rd(4, d);  chk("R1 control after reset", d, 0);
        rd(8, d);  chk("R1 baud after reset", d, 0);
        chk("R1 irq low", 32'(irq), 0);
        chk("R1 tx empty", 32'(tx_empty), 1);
    endtask

    task automatic t_regs();
        logic [31:0] d, c;
        c = (32'd3 << 22) | (32'hA5 << 14) | (32'd1 << 13) | (32'd1 << 11) | (32'd1 << 9) | (32'd5 << 6);
        wr(4, c);
        rd(4, d); chk("R2 control readback", d, c);
        chk("R2 word bits", 32'(cfg_word_bits), 5);
        chk("R2 parity en/even", {30'd0, cfg_parity_en, cfg_parity_even}, 2);
        chk("R2 stop/flow/force", {29'd0, cfg_two_stop, cfg_flow_en, cfg_force_low}, 5);
        chk("R2 rdy delay", 32'(cfg_rdy_delay), 32'hA5);
        wr(8, 32'h1234ABCD);
        rd(8, d); chk("R2 baud readback", d, 32'hABCD);
        chk("R2 baud output", 32'(baud_cfg), 32'hABCD);
        rd(12, d); chk("R2 command reads zero", d, 0);
        wr(4, 0);
    endtask

    task automatic t_tx();
        logic [31:0] d;
        for (int i = 0; i < 17; i++) wr(0, 32'h40 + i);
        rd(16, d);
        chk("R3 tx count full", (d >> 11) & 31, 16);
        chk("R6 trdy still sticky", (d >> 1) & 1, 1);
        chk("R3 tx head", 32'(tx_char), 32'h40);
        wr(12, 32'd1 << 13);
        rd(16, d); chk("R9 trdy cleared above threshold", (d >> 1) & 1, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R3 tx order", 32'(tx_char), 32'h40 + i);
            tx_pop = 1'b1;
            @(negedge clk);
            tx_pop = 1'b0;
        end
        chk("R3 overflow char dropped", 32'(tx_empty), 1);
        @(negedge clk);
        rd(16, d); chk("R9 trdy back at count 0", (d >> 1) & 1, 1);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        wr(4, 32'd2 << 22);
        for (int i = 0; i < 3; i++) wr(0, 32'h60 + i);
        wr(12, 32'd1 << 13);
        rd(16, d); chk("R9 clear holds at 3>2", (d >> 1) & 1, 0);
        wr(12, 32'd1 << 14);
        rd(16, d); chk("R9 set command", (d >> 1) & 1, 1);
        wr(12, 32'd1 << 13);
        @(negedge clk);
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
        rd(16, d); chk("R9 trdy not yet set", (d >> 1) & 1, 0);
        @(negedge clk);
        rd(16, d); chk("R9 trdy set at count 2", (d >> 1) & 1, 1);
        wr(12, 32'd1 << 12);
        rd(16, d); chk("R5 tx clear", (d >> 11) & 31, 0);
        wr(4, 0);
    endtask

    task automatic t_rx();
        logic [31:0] d;
        rx_in(8'hA1); rx_in(8'hA2); rx_in(8'hA3);
        rd(16, d);
        chk("R7 rrdy set", d & 1, 1);
        chk("R6 rx count", (d >> 6) & 31, 3);
        rd(0, d); chk("R4 head", d, 32'hA1);
        @(negedge clk);
        rd(0, d); chk("R4 read does not pop", d, 32'hA1);
        wr(12, 32'd1 << 10);
        rd(0, d); chk("R4 pop command", d, 32'hA2);
        rd(16, d); chk("R4 count after pop", (d >> 6) & 31, 2);
        wr(12, 32'd1 << 11);
        rd(16, d); chk("R5 rx clear", (d >> 6) & 31, 0);
        wr(12, 32'd1 << 10);
        rd(16, d); chk("R12 pop on empty", (d >> 6) & 31, 0);
        wr(12, 32'd1);
        rd(16, d); chk("R8 rrdy clear", d & 1, 0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) rx_in(8'(i));
        rd(16, d); chk("R7 no overrun at 16", (d >> 2) & 1, 0);
        rx_in(8'h10);
        rd(16, d);
        chk("R7 overrun set", (d >> 2) & 1, 1);
        chk("R7 count stays 16", (d >> 6) & 31, 16);
        rd(0, d); chk("R7 head kept", d, 0);
        wr(12, (32'd1 << 11) | (32'd1 << 1) | 32'd1);
        rd(16, d); chk("R8 overrun and rrdy cleared", d, 32'h2);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        @(negedge clk);
        rx_break = 1'b1; rx_frame_err = 1'b1; rx_parity_err = 1'b1;
        @(negedge clk);
        rx_break = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
        rd(16, d); chk("R7 line error flags", d & 32'h3D, 32'h38);
        wr(12, 32'h1F);
        rd(16, d); chk("R8 clear five", d & 32'h3D, 0);
        wr(12, 32'h1F << 5);
        rd(16, d); chk("R8 set five", d & 32'h3D, 32'h3D);
        wr(12, 32'h1F);
        rd(16, d); chk("R8 clear again", d & 32'h3D, 0);
    endtask

    task automatic t_conflict();
        logic [31:0] d;
        @(negedge clk);
        bus_addr = 12; bus_wdata = (32'd1 << 3) | 32'd1; bus_wr = 1'b1;
        rx_frame_err = 1'b1; rx_push = 1'b1; rx_char = 8'h77;
        @(negedge clk);
        bus_wr = 1'b0; rx_frame_err = 1'b0; rx_push = 1'b0;
        rd(16, d); chk("R10 fe and rrdy survive clear", d & 32'h11, 32'h11);
        wr(12, (32'd1 << 11) | (32'd1 << 3) | 32'd1);
        rd(16, d); chk("R10 plain clear works", d & 32'h11, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(4, 32'd1 << 3);
        wr(12, 32'd1 << 9);
        @(negedge clk);
        chk("R11 disabled flag no irq", 32'(irq), 0);
        wr(12, 32'd1 << 8);
        chk("R11 irq one cycle late", 32'(irq), 0);
        @(negedge clk);
        chk("R11 irq raised", 32'(irq), 1);
        wr(12, 32'd1 << 3);
        chk("R11 irq holds one cycle", 32'(irq), 1);
        @(negedge clk);
        chk("R11 irq dropped", 32'(irq), 0);
        wr(12, 32'd1 << 4);
        wr(4, 0);
        rd(16, d); chk("R6 final status", d, 32'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_regs();
        t_tx();
        t_thresh();
        t_rx();
        t_overrun();
        t_flags();
        t_conflict();
        t_irq();
        finish_run();
    end
endmodule